// File: doc/BRIEF.md
# Interrupt Line to Priority-Level Mapper

This block gathers eight level-sensitive interrupt request lines and presents them to a processor as sixteen raw priority-level lines. Each request line is tied to one fixed priority level through a sparse table. Some lines are tied to level 0, which marks them as unused, so they can never raise anything. The processor sees one line per level. It does its own priority encoding and acknowledge handling.

A pending flag for each usable request line follows that line's level. A level output is high when interrupts are enabled and at least one pending flag maps to that level. A single byte-wide control register sits behind a zero-wait-state read/write strobe port. Bit 0 of that register is the master enable. Bit 6 cannot be stored.

The level outputs come from flip-flops. They follow a change on a request line or a register write on the very next clock edge.

Top module: `irq_level_map`

## Requirements
- R1: Request line i drives priority level L(i), with L = 0, 1, 4, 6, 8, 10, 0, 14 for i = 0 to 7. lvl_out bit n is the line for level n.
- R2: Request lines 0 and 6 map to level 0 and are ignored: their pending flags stay clear, and raising them changes no output.
- R3: The pending flag of each usable line copies that line's level on every clock edge. It is not edge-latched, so a line that drops clears its flag.
- R4: lvl_out bit n is high exactly when the enable bit is 1 and at least one pending flag maps to level n. Several lines with distinct levels raise several outputs at once.
- R5: lvl_out reflects the request lines and the control register as they stood at the most recent rising clock edge. Its latency is one cycle.
- R6: A write (reg_wr high at a clock edge) stores reg_wdata AND 0xBF. Bit 6 of the register always reads back 0.
- R7: While reg_rd is high, reg_rdata shows the stored register value in the same cycle, and shows the old value if a write lands at the coming edge. While reg_rd is low, reg_rdata is 0.
- R8: Control bit 0 is the master enable. When it is 0, every lvl_out bit is low, but pending flags keep tracking the inputs. Setting it again raises the levels of lines still held high at the next edge.
- R9: An active-low asynchronous reset sets the control register to 0x01, clears every pending flag and drives lvl_out to 0.
- R10: lvl_out bit 0 is never asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 8 | Level-sensitive interrupt request lines |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_rd | input | 1 | Read strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, zero when not reading |
| lvl_out | output | 16 | One line per priority level |

## Verification
On every cycle, the checker enforces four relations:
- pending flags copy the previous cycle's usable request bits;
- no level line is high without an enabled pending source, and every enabled pending source raises its own level, which keeps level 0 quiet;
- the read port returns the stored value and the write mask holds;
- the state seen on leaving reset matches R9.

Only the bench scenarios show certain sequences:
- the exact one-edge timing of a write that enables interrupts and a request change landing together;
- a read that overlaps a write and returns the old value;
- pending flags surviving a disabled period, traced through the outputs once interrupts are enabled again.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

   // Register storage word used by the control port.
   typedef logic [7:0] ctl_byte_t;

   // How the level lines leave the block.
   typedef enum logic {
      LVL_OUT_COMB = 1'b0,
      LVL_OUT_FLOP = 1'b1
   } lvl_out_mode_e;

   // Level table, one byte per request line, line 0 in the low byte.
   localparam logic [63:0] DEF_LVL_TABLE = 64'h0E00_0A08_0604_0100;
   localparam ctl_byte_t   DEF_CTL_RST   = 8'h01;
   localparam ctl_byte_t   DEF_CTL_WMASK = 8'hBF;

endpackage

// File: rtl/irqmap_ctl_reg.sv
module irqmap_ctl_reg #(
   parameter int               CTL_W     = 8,
   parameter logic [CTL_W-1:0] CTL_RST   = 8'h01,
   parameter logic [CTL_W-1:0] CTL_WMASK = 8'hBF,
   parameter int               EN_BIT    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] ctl_q,
   output logic             en_nxt
);

   logic [CTL_W-1:0] ctl_nxt;

   // Masked bits are dropped before storage.
   always_comb ctl_nxt = wr_en ? (wdata & CTL_WMASK) : ctl_q;

   assign en_nxt = ctl_nxt[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_RST;
      else        ctl_q <= ctl_nxt;
   end

endmodule

// File: rtl/irqmap_pend.sv
module irqmap_pend #(
   parameter int                        NUM_IRQ   = 8,
   parameter int                        TBL_EW    = 8,
   parameter logic [NUM_IRQ*TBL_EW-1:0] LVL_TABLE = 64'h0E00_0A08_0604_0100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] req,
   output logic [NUM_IRQ-1:0] pend_nxt,
   output logic [NUM_IRQ-1:0] pend_q
);

   // A line is usable when its table entry is a nonzero level.
   function automatic logic [NUM_IRQ-1:0] usable_mask();
      logic [NUM_IRQ-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         m[i] = (LVL_TABLE[i*TBL_EW +: TBL_EW] != '0);
      return m;
   endfunction

   localparam logic [NUM_IRQ-1:0] LIVE = usable_mask();

   // Level-following: the flag is a plain copy of the line, not a set/clear latch.
   assign pend_nxt = req & LIVE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_nxt;
   end

endmodule

// File: rtl/irqmap_lvl.sv
module irqmap_lvl
   import irqmap_pkg::*;
#(
   parameter int                        NUM_IRQ   = 8,
   parameter int                        NUM_LVL   = 16,
   parameter int                        TBL_EW    = 8,
   parameter logic [NUM_IRQ*TBL_EW-1:0] LVL_TABLE = 64'h0E00_0A08_0604_0100,
   parameter lvl_out_mode_e             OUT_MODE  = LVL_OUT_FLOP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] pend,
   input  logic               en,
   output logic [NUM_LVL-1:0] lvl
);

   // Set of request lines feeding level n; level 0 collects nothing.
   function automatic logic [NUM_IRQ-1:0] src_mask(int n);
      logic [NUM_IRQ-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         m[i] = (n != 0) && (int'(LVL_TABLE[i*TBL_EW +: TBL_EW]) == n);
      return m;
   endfunction

   logic [NUM_LVL-1:0] lvl_c;

   for (genvar n = 0; n < NUM_LVL; n++) begin : g_lvl
      localparam logic [NUM_IRQ-1:0] SRC = src_mask(n);
      if (SRC == '0) begin : g_none
         assign lvl_c[n] = 1'b0;
      end else begin : g_any
         assign lvl_c[n] = en & (|(pend & SRC));
      end
   end

   if (OUT_MODE == LVL_OUT_FLOP) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl <= '0;
         else        lvl <= lvl_c;
      end
   end else begin : g_comb
      assign lvl = lvl_c;
   end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
   import irqmap_pkg::*;
#(
   parameter int                        NUM_IRQ   = 8,
   parameter int                        NUM_LVL   = 16,
   parameter int                        TBL_EW    = 8,
   parameter int                        CTL_W     = 8,
   parameter logic [NUM_IRQ*TBL_EW-1:0] LVL_TABLE = DEF_LVL_TABLE,
   parameter logic [CTL_W-1:0]          CTL_RST   = DEF_CTL_RST,
   parameter logic [CTL_W-1:0]          CTL_WMASK = DEF_CTL_WMASK,
   parameter int                        EN_BIT    = 0,
   parameter lvl_out_mode_e             OUT_MODE  = LVL_OUT_FLOP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [CTL_W-1:0]   reg_wdata,
   output logic [CTL_W-1:0]   reg_rdata,
   output logic [NUM_LVL-1:0] lvl_out
);

   // ---------------- elaboration-time parameter checks ----------------
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("irq_level_map: NUM_IRQ must be at least 1");
   end
   if (NUM_LVL < 2 || NUM_LVL > (1 << TBL_EW)) begin : g_bad_lvl
      $error("irq_level_map: NUM_LVL must fit the table entry width");
   end
   if (EN_BIT < 0 || EN_BIT >= CTL_W) begin : g_bad_en
      $error("irq_level_map: EN_BIT outside the control register");
   end else if (!CTL_WMASK[EN_BIT]) begin : g_bad_mask
      $error("irq_level_map: write mask must keep the enable bit");
   end
   if ((CTL_RST & ~CTL_WMASK) != '0) begin : g_bad_rst
      $error("irq_level_map: reset value sets a bit the write mask clears");
   end
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tbl_chk
      if (int'(LVL_TABLE[i*TBL_EW +: TBL_EW]) >= NUM_LVL) begin : g_bad_entry
         $error("irq_level_map: table entry names a level beyond NUM_LVL");
      end
   end

   // ---------------- datapath ----------------
   logic [CTL_W-1:0]   ctl_q;
   logic               en_nxt;
   logic [NUM_IRQ-1:0] pend_q;
   logic [NUM_IRQ-1:0] pend_nxt;
   logic [NUM_IRQ-1:0] map_pend;
   logic               map_en;

   irqmap_ctl_reg #(
      .CTL_W    (CTL_W),
      .CTL_RST  (CTL_RST),
      .CTL_WMASK(CTL_WMASK),
      .EN_BIT   (EN_BIT)
   ) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr),
      .wdata (reg_wdata),
      .ctl_q (ctl_q),
      .en_nxt(en_nxt)
   );

   irqmap_pend #(
      .NUM_IRQ  (NUM_IRQ),
      .TBL_EW   (TBL_EW),
      .LVL_TABLE(LVL_TABLE)
   ) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (irq_req),
      .pend_nxt(pend_nxt),
      .pend_q  (pend_q)
   );

   // A registered output is fed from next-state values so it lags by one edge only.
   if (OUT_MODE == LVL_OUT_FLOP) begin : g_src_next
      assign map_pend = pend_nxt;
      assign map_en   = en_nxt;
   end else begin : g_src_now
      assign map_pend = pend_q;
      assign map_en   = ctl_q[EN_BIT];
   end

   irqmap_lvl #(
      .NUM_IRQ  (NUM_IRQ),
      .NUM_LVL  (NUM_LVL),
      .TBL_EW   (TBL_EW),
      .LVL_TABLE(LVL_TABLE),
      .OUT_MODE (OUT_MODE)
   ) u_lvl (
      .clk  (clk),
      .rst_n(rst_n),
      .pend (map_pend),
      .en   (map_en),
      .lvl  (lvl_out)
   );

   assign reg_rdata = reg_rd ? ctl_q : '0;

endmodule

// File: rtl/irq_level_map_chk.sv
module irq_level_map_chk #(
   parameter int                        NUM_IRQ   = 8,
   parameter int                        NUM_LVL   = 16,
   parameter int                        TBL_EW    = 8,
   parameter int                        CTL_W     = 8,
   parameter logic [NUM_IRQ*TBL_EW-1:0] LVL_TABLE = 64'h0E00_0A08_0604_0100,
   parameter logic [CTL_W-1:0]          CTL_RST   = 8'h01,
   parameter logic [CTL_W-1:0]          CTL_WMASK = 8'hBF,
   parameter int                        EN_BIT    = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] irq_req,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [CTL_W-1:0]   reg_wdata,
   input logic [CTL_W-1:0]   reg_rdata,
   input logic [NUM_LVL-1:0] lvl_out,
   input logic [CTL_W-1:0]   ctl_q,
   input logic [NUM_IRQ-1:0] pend_q
);

   function automatic logic [NUM_IRQ-1:0] feeders(int n);
      logic [NUM_IRQ-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         m[i] = (n != 0) && (int'(LVL_TABLE[i*TBL_EW +: TBL_EW]) == n);
      return m;
   endfunction

   function automatic logic [NUM_IRQ-1:0] usable();
      logic [NUM_IRQ-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_IRQ; i++)
         m[i] = (LVL_TABLE[i*TBL_EW +: TBL_EW] != '0);
      return m;
   endfunction

   localparam logic [NUM_IRQ-1:0] LIVE = usable();

   // Set once a clock edge has passed outside reset, so $past is meaningful.
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   a_r9_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctl_q == CTL_RST && pend_q == '0 && lvl_out == '0));

   // R2 and R3: usable flags copy the line, ignored flags stay clear.
   a_r3_pend_follow: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pend_q == ($past(irq_req) & LIVE));

   a_r6_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> ctl_q == ($past(reg_wdata) & CTL_WMASK));

   a_r6_bit6_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~CTL_WMASK) == '0);

   a_r7_read_value: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> reg_rdata == ctl_q);

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |-> reg_rdata == '0);

   a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[EN_BIT] |-> lvl_out == '0);

   // R4 with R10: a high level always has an enabled pending feeder (level 0 has none).
   for (genvar n = 0; n < NUM_LVL; n++) begin : g_lvl_chk
      localparam logic [NUM_IRQ-1:0] FEED = feeders(n);
      a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         lvl_out[n] |-> (ctl_q[EN_BIT] && ((pend_q & FEED) != '0)));
   end

   // R1: every enabled pending line raises its own table level.
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_map_chk
      localparam int LV = int'(LVL_TABLE[i*TBL_EW +: TBL_EW]);
      if (LV != 0) begin : g_live
         a_r1_line_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q[EN_BIT] && pend_q[i]) |-> lvl_out[LV]);
      end
   end

endmodule

bind irq_level_map irq_level_map_chk #(
   .NUM_IRQ  (NUM_IRQ),
   .NUM_LVL  (NUM_LVL),
   .TBL_EW   (TBL_EW),
   .CTL_W    (CTL_W),
   .LVL_TABLE(LVL_TABLE),
   .CTL_RST  (CTL_RST),
   .CTL_WMASK(CTL_WMASK),
   .EN_BIT   (EN_BIT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .lvl_out  (lvl_out),
   .ctl_q    (ctl_q),
   .pend_q   (pend_q)
);

// File: tb/sim_irq_level_map.sv
`timescale 1ns/100ps
module sim_irq_level_map;

   localparam real HALF = 2.5;
   localparam int  WD_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  irq_req = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [15:0] lvl_out;

   irq_level_map u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_req  (irq_req),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .lvl_out  (lvl_out)
   );

   always #(HALF) clk = ~clk;

   typedef struct {
      logic [15:0] lvl;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   // Level of each request line (R1); 0 means ignored (R2).
   int   lvl_of [8] = '{0, 1, 4, 6, 8, 10, 0, 14};
   logic [7:0] m_ctl = 8'h01;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] model_lvl(input logic [7:0] req, input logic [7:0] ctl);
      logic [15:0] r;
      r = '0;
      if (ctl[0])
         for (int i = 0; i < 8; i++)
            if (req[i] && lvl_of[i] != 0) r[lvl_of[i]] = 1'b1;
      return r;
   endfunction

   // Driver: one bus cycle; checks read data now, queues the level result for the monitor.
   task automatic step(input logic [7:0] irq, input logic wr, input logic [7:0] wd,
                       input logic rd, input string tag);
      exp_t e;
      @(negedge clk);
      #0.5;
      irq_req = irq; reg_wr = wr; reg_wdata = wd; reg_rd = rd;
      #0.5;
      if (rd) chk(reg_rdata == m_ctl, {tag, " (R7 read data)"}, {8'h0, reg_rdata}, {8'h0, m_ctl});
      else    chk(reg_rdata == 8'h00, "R7 idle read data", {8'h0, reg_rdata}, 16'h0);
      if (wr) m_ctl = wd & 8'hBF;
      e.lvl = model_lvl(irq, m_ctl);
      e.tag = tag;
      q.push_back(e);
   endtask

   // Monitor: one negedge after the driving cycle the design has taken one edge.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(lvl_out == e.lvl, e.tag, lvl_out, e.lvl);
      end
   end

   task automatic do_reset();
      @(negedge clk);
      #0.5;
      rst_n = 1'b0;
      irq_req = '0; reg_wr = 1'b0; reg_rd = 1'b0;
      #1;
      chk(lvl_out == 16'h0, "R9 outputs low in reset", lvl_out, 16'h0);
      repeat (2) @(negedge clk);
      #0.5;
      rst_n = 1'b1;
      m_ctl = 8'h01;
   endtask

   initial begin
      #(HALF * 2 * WD_CYCLES);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1;
      chk(lvl_out == 16'h0, "R9 outputs low at reset", lvl_out, 16'h0);
      repeat (3) @(negedge clk);
      #0.5;
      rst_n = 1'b1;

      step(8'h00, 1'b0, 8'h00, 1'b1, "R9 reset register value");

      for (int i = 0; i < 8; i++)
         step(8'(1 << i), 1'b0, 8'h00, 1'b0,
              (lvl_of[i] == 0) ? "R2/R10 ignored line" : "R1 single line level");

      step(8'hFF, 1'b0, 8'h00, 1'b0, "R4 all lines at once");
      step(8'hA0, 1'b0, 8'h00, 1'b0, "R4 two lines");
      step(8'h41, 1'b0, 8'h00, 1'b0, "R2 only ignored lines");
      step(8'h00, 1'b0, 8'h00, 1'b0, "R3 release clears");
      step(8'h80, 1'b0, 8'h00, 1'b0, "R5 rise seen after one edge");
      step(8'h00, 1'b0, 8'h00, 1'b0, "R5 fall seen after one edge");

      step(8'h04, 1'b1, 8'hFF, 1'b0, "R6 write all ones");
      step(8'h04, 1'b0, 8'h00, 1'b1, "R6 bit 6 reads zero");
      step(8'h04, 1'b1, 8'h40, 1'b1, "R7 read during write gives old value");
      step(8'h04, 1'b0, 8'h00, 1'b1, "R6 write of bit 6 alone stores zero");

      step(8'h80, 1'b0, 8'h00, 1'b0, "R8 disabled holds outputs low");
      step(8'h22, 1'b0, 8'h00, 1'b0, "R8 disabled with two lines");
      step(8'h22, 1'b1, 8'h01, 1'b0, "R8 enable restores pending lines");
      step(8'h22, 1'b1, 8'hFE, 1'b1, "R8 clear enable bit");
      step(8'h08, 1'b1, 8'h41, 1'b1, "R8 enable with line change same cycle");
      step(8'h08, 1'b0, 8'h00, 1'b1, "R6 enable write masked");
      step(8'h88, 1'b0, 8'h00, 1'b0, "R4 levels 6 and 14");

      step(8'hFF, 1'b1, 8'h03, 1'b0, "R1 all lines before reset");
      @(negedge clk);
      @(negedge clk);
      do_reset();
      step(8'h00, 1'b0, 8'h00, 1'b1, "R9 register after reset");
      step(8'h02, 1'b0, 8'h00, 1'b0, "R9 pending cleared then R1 line 1");
      step(8'h00, 1'b0, 8'h00, 1'b0, "R3 idle after reset");

      repeat (2) @(negedge clk);
      #1;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule